// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the operand address for a 16-bit segmented processor. Given an addressing-mode code, a selector naming one of the eight general registers, the current contents of the four registers allowed to act as pointers, a displacement and the two data-side segment registers, it returns the 16-bit offset, which of the two segments applies, whether the access is based or indexed, and the 20-bit physical address.

The segment is never named by the request. Whenever the stack-frame pointer acts as the pointer, the stack segment is chosen; every other case uses the data segment. The physical address is the segment value moved up four bit places plus the offset. A selector that names a register with no pointer role raises an error flag and zeroes the address outputs. By default the results pass through one output register that loads on a valid strobe. With the `REGISTERED` parameter set to 0, the results come straight from the combinational path.

Top module: `seg_ea_gen`

## Requirements
- R1: The physical output equals (segment << 4) + offset, truncated to 20 bits. Segment 05C0h with offset 0050h yields 05C50h, and segment FFFFh with offset 0010h yields 00000h.
- R2: Mode code 0 (direct) and mode code 3 (reserved, treated the same way) give an offset equal to the extended displacement. The segment is the data segment, the class is 0, the error flag is 0, and the selector has no effect.
- R3: Mode code 1 (register indirect) gives an offset equal to the selected pointer register, and the displacement has no effect.
- R4: Mode code 2 (register plus displacement) gives an offset equal to the pointer register plus the extended displacement, taken modulo 2^16. A negative displacement subtracts.
- R5: When `disp_short` is 1, the displacement is bits 7:0 sign-extended to 16 bits, and bits 15:8 have no effect. When it is 0, all 16 bits are used as a two's-complement value.
- R6: Selector code 5 (BP) in modes 1 and 2 selects the stack segment (`seg_stack`=1). Selector codes 3 (BX), 6 (SI) and 7 (DI) select the data segment.
- R7: The class output is 1 (based) for BX or BP and 2 (indexed) for SI or DI. It is 0 in direct mode.
- R8: In modes 1 and 2, selector codes 0 (AX), 1 (CX), 2 (DX) and 4 (SP) set `bad_ptr`. In that case the offset, physical address, class and `seg_stack` outputs are all 0.
- R9: With the output register present, outputs take the new values on the clock edge where `in_valid` is 1. They hold while `in_valid` is 0, and `out_valid` is `in_valid` delayed by one cycle.
- R10: A synchronous active-high reset clears every output, including `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, loads the output register |
| mode | input | 2 | 0 direct, 1 register indirect, 2 register plus displacement, 3 reserved (as direct) |
| ptr_sel | input | 3 | Register code: 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI |
| bx_val | input | 16 | Base register contents |
| bp_val | input | 16 | Stack-frame base register contents |
| si_val | input | 16 | Source index contents |
| di_val | input | 16 | Destination index contents |
| disp | input | 16 | Displacement |
| disp_short | input | 1 | 1: use bits 7:0 sign-extended |
| ds_val | input | 16 | Data segment value |
| ss_val | input | 16 | Stack segment value |
| out_valid | output | 1 | Registered request strobe |
| bad_ptr | output | 1 | Selector names a non-pointer register |
| seg_stack | output | 1 | 1: stack segment used, 0: data segment |
| addr_class | output | 2 | 0 none, 1 based, 2 indexed |
| ea | output | 16 | Effective address (offset) |
| phys | output | 20 | Physical address |

## Verification
Two wraps can happen in the same request. The offset sum can overflow 16 bits while the segment-plus-offset sum also passes 20 bits. The bench provokes this with BP holding FFF0h, a displacement of 0020h and the stack segment at FFFFh, so the offset wraps to 0010h and the physical sum wraps to 00000h. A behavioural reference model, written with integer arithmetic and explicit modulo, judges the result on every clock. The same model also covers a short negative displacement crossing zero and an illegal selector that arrives with a non-zero displacement.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_REG      = 2'd1,
        AM_REG_DISP = 2'd2,
        AM_RSVD     = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        PR_AX = 3'd0,
        PR_CX = 3'd1,
        PR_DX = 3'd2,
        PR_BX = 3'd3,
        PR_SP = 3'd4,
        PR_BP = 3'd5,
        PR_SI = 3'd6,
        PR_DI = 3'd7
    } preg_e;

    typedef enum logic [1:0] {
        AC_NONE    = 2'd0,
        AC_BASED   = 2'd1,
        AC_INDEXED = 2'd2
    } aclass_e;

endpackage

// File: rtl/seg_agu_ptr_sel.sv
module seg_agu_ptr_sel
    import seg_agu_pkg::*;
#(
    parameter int unsigned OFS_W = 16
) (
    input  logic [1:0]       mode_i,
    input  logic [2:0]       sel_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    output logic [OFS_W-1:0] ptr_o,
    output logic             stack_o,
    output logic [1:0]       cls_o,
    output logic             bad_o
);

    logic             needs_ptr;
    logic [OFS_W-1:0] ptr_raw;
    logic             stack_raw;
    logic [1:0]       cls_raw;
    logic             bad_raw;

    always_comb begin
        needs_ptr = (mode_i == AM_REG) || (mode_i == AM_REG_DISP);
        ptr_raw   = '0;
        stack_raw = 1'b0;
        cls_raw   = AC_NONE;
        bad_raw   = 1'b0;
        case (sel_i)
            PR_BX: begin
                ptr_raw = bx_i;
                cls_raw = AC_BASED;
            end
            PR_BP: begin
                ptr_raw   = bp_i;
                stack_raw = 1'b1;
                cls_raw   = AC_BASED;
            end
            PR_SI: begin
                ptr_raw = si_i;
                cls_raw = AC_INDEXED;
            end
            PR_DI: begin
                ptr_raw = di_i;
                cls_raw = AC_INDEXED;
            end
            default: bad_raw = 1'b1;
        endcase
    end

    always_comb begin
        if (needs_ptr && !bad_raw) begin
            ptr_o   = ptr_raw;
            stack_o = stack_raw;
            cls_o   = cls_raw;
        end else begin
            ptr_o   = '0;
            stack_o = 1'b0;
            cls_o   = AC_NONE;
        end
        bad_o = needs_ptr && bad_raw;
    end

endmodule

// File: rtl/seg_agu_offset.sv
module seg_agu_offset
    import seg_agu_pkg::*;
#(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [OFS_W-1:0] ptr_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic             short_i,
    output logic [OFS_W-1:0] ea_o
);

    localparam int unsigned EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] disp_ext;

    always_comb begin
        if (short_i) begin
            disp_ext = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        end else begin
            disp_ext = disp_i;
        end
        case (mode_i)
            AM_REG:      ea_o = ptr_i;
            AM_REG_DISP: ea_o = ptr_i + disp_ext;
            default:     ea_o = disp_ext;
        endcase
    end

endmodule

// File: rtl/seg_agu_phys.sv
module seg_agu_phys #(
    parameter int unsigned OFS_W = 16,
    parameter int unsigned SHIFT = 4
) (
    input  logic [OFS_W-1:0]       seg_i,
    input  logic [OFS_W-1:0]       ea_i,
    output logic [OFS_W+SHIFT-1:0] phys_o
);

    localparam int unsigned PHYS_W = OFS_W + SHIFT;

    logic [PHYS_W-1:0] seg_shifted;
    logic [PHYS_W-1:0] ea_wide;

    always_comb begin
        seg_shifted = {seg_i, {SHIFT{1'b0}}};
        ea_wide     = {{SHIFT{1'b0}}, ea_i};
        phys_o      = seg_shifted + ea_wide;
    end

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import seg_agu_pkg::*;
#(
    parameter int unsigned OFS_W      = 16,
    parameter int unsigned SHIFT      = 4,
    parameter int unsigned SHORT_W    = 8,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             mode,
    input  logic [2:0]             ptr_sel,
    input  logic [OFS_W-1:0]       bx_val,
    input  logic [OFS_W-1:0]       bp_val,
    input  logic [OFS_W-1:0]       si_val,
    input  logic [OFS_W-1:0]       di_val,
    input  logic [OFS_W-1:0]       disp,
    input  logic                   disp_short,
    input  logic [OFS_W-1:0]       ds_val,
    input  logic [OFS_W-1:0]       ss_val,
    output logic                   out_valid,
    output logic                   bad_ptr,
    output logic                   seg_stack,
    output logic [1:0]             addr_class,
    output logic [OFS_W-1:0]       ea,
    output logic [OFS_W+SHIFT-1:0] phys
);

    localparam int unsigned PHYS_W = OFS_W + SHIFT;

    typedef struct packed {
        logic              valid;
        logic              bad;
        logic              stack;
        logic [1:0]        cls;
        logic [OFS_W-1:0]  ea;
        logic [PHYS_W-1:0] phys;
    } agu_out_t;

    logic [OFS_W-1:0]  ptr_w;
    logic              stack_w;
    logic [1:0]        cls_w;
    logic              bad_w;
    logic [OFS_W-1:0]  ea_w;
    logic [OFS_W-1:0]  seg_w;
    logic [PHYS_W-1:0] phys_w;
    agu_out_t          comb_d;

    seg_agu_ptr_sel #(.OFS_W(OFS_W)) u_ptr (
        .mode_i  (mode),
        .sel_i   (ptr_sel),
        .bx_i    (bx_val),
        .bp_i    (bp_val),
        .si_i    (si_val),
        .di_i    (di_val),
        .ptr_o   (ptr_w),
        .stack_o (stack_w),
        .cls_o   (cls_w),
        .bad_o   (bad_w)
    );

    seg_agu_offset #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
        .mode_i  (mode),
        .ptr_i   (ptr_w),
        .disp_i  (disp),
        .short_i (disp_short),
        .ea_o    (ea_w)
    );

    assign seg_w = stack_w ? ss_val : ds_val;

    seg_agu_phys #(.OFS_W(OFS_W), .SHIFT(SHIFT)) u_phys (
        .seg_i  (seg_w),
        .ea_i   (ea_w),
        .phys_o (phys_w)
    );

    always_comb begin
        comb_d.valid = in_valid;
        comb_d.bad   = bad_w;
        comb_d.stack = stack_w;
        comb_d.cls   = cls_w;
        comb_d.ea    = bad_w ? '0 : ea_w;
        comb_d.phys  = bad_w ? '0 : phys_w;
    end

    generate
        if (REGISTERED) begin : g_reg
            agu_out_t out_d;
            agu_out_t out_q;

            always_comb begin
                out_d       = out_q;
                out_d.valid = in_valid;
                if (in_valid) begin
                    out_d = comb_d;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end

            assign out_valid  = out_q.valid;
            assign bad_ptr    = out_q.bad;
            assign seg_stack  = out_q.stack;
            assign addr_class = out_q.cls;
            assign ea         = out_q.ea;
            assign phys       = out_q.phys;

            a_r8_bad_zeroes: assert property (@(posedge clk) disable iff (rst)
                bad_ptr |-> (ea == '0 && phys == '0 && addr_class == AC_NONE && !seg_stack));

            a_r6_stack_is_based: assert property (@(posedge clk) disable iff (rst)
                seg_stack |-> (addr_class == AC_BASED));

            a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);

            a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(ea) && $stable(phys) && !out_valid));

            a_r2_direct_data_seg: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (mode == AM_DIRECT || mode == AM_RSVD))
                    |=> (!seg_stack && !bad_ptr && addr_class == AC_NONE));

            a_r10_reset_clears: assert property (@(posedge clk)
                rst |=> (!out_valid && ea == '0 && phys == '0 && !bad_ptr));
        end else begin : g_comb
            assign out_valid  = comb_d.valid;
            assign bad_ptr    = comb_d.bad;
            assign seg_stack  = comb_d.stack;
            assign addr_class = comb_d.cls;
            assign ea         = comb_d.ea;
            assign phys       = comb_d.phys;
        end
    endgenerate

endmodule

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  ptr_sel = 3'd0;
    logic [15:0] bx_val = 16'h0004;
    logic [15:0] bp_val = 16'hFFF0;
    logic [15:0] si_val = 16'h0100;
    logic [15:0] di_val = 16'h0001;
    logic [15:0] disp = 16'h0000;
    logic        disp_short = 1'b0;
    logic [15:0] ds_val = 16'h05C0;
    logic [15:0] ss_val = 16'hFFFF;

    logic        out_valid;
    logic        bad_ptr;
    logic        seg_stack;
    logic [1:0]  addr_class;
    logic [15:0] ea;
    logic [19:0] phys;

    seg_ea_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .ptr_sel(ptr_sel),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .disp(disp), .disp_short(disp_short), .ds_val(ds_val), .ss_val(ss_val),
        .out_valid(out_valid), .bad_ptr(bad_ptr), .seg_stack(seg_stack),
        .addr_class(addr_class), .ea(ea), .phys(phys)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_tag = "R10 reset";
    string exp_tag = "R10 reset";

    logic        e_valid = 0;
    logic        e_bad = 0;
    logic        e_stack = 0;
    logic [1:0]  e_cls = 0;
    logic [15:0] e_ea = 0;
    logic [19:0] e_phys = 0;

    function automatic logic [39:0] ref_calc(
        input logic [1:0] m, input logic [2:0] s, input logic [15:0] d, input logic sh);
        int dv, p, sum, seg, ph;
        logic bad, stk;
        logic [1:0] cls;
        bad = 0; stk = 0; cls = 0; p = 0;
        if (sh) dv = d[7] ? int'(d[7:0]) - 256 : int'(d[7:0]);
        else    dv = d[15] ? int'(d) - 65536 : int'(d);
        if (m == 2'd1 || m == 2'd2) begin
            case (s)
                3'd3: begin p = int'(bx_val); cls = 1; end
                3'd5: begin p = int'(bp_val); cls = 1; stk = 1; end
                3'd6: begin p = int'(si_val); cls = 2; end
                3'd7: begin p = int'(di_val); cls = 2; end
                default: bad = 1;
            endcase
        end
        if (m == 2'd1)      sum = p;
        else if (m == 2'd2) sum = p + dv;
        else                sum = dv;
        sum = sum % 65536;
        if (sum < 0) sum = sum + 65536;
        seg = stk ? int'(ss_val) : int'(ds_val);
        ph = (seg * 16 + sum) % 1048576;
        if (bad) return {1'b1, 1'b0, 2'd0, 16'd0, 20'd0};
        return {1'b0, stk, cls, sum[15:0], ph[19:0]};
    endfunction

    always @(posedge clk) begin
        started <= 1;
        exp_tag <= cur_tag;
        if (rst) begin
            e_valid <= 0; e_bad <= 0; e_stack <= 0; e_cls <= 0; e_ea <= 0; e_phys <= 0;
        end else begin
            e_valid <= in_valid;
            if (in_valid)
                {e_bad, e_stack, e_cls, e_ea, e_phys} <= ref_calc(mode, ptr_sel, disp, disp_short);
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if ({out_valid, bad_ptr, seg_stack, addr_class, ea, phys} !==
                {e_valid, e_bad, e_stack, e_cls, e_ea, e_phys}) begin
                fails++;
                $display("FAIL %s: got v=%0b bad=%0b stk=%0b cls=%0d ea=%h phys=%h, expected v=%0b bad=%0b stk=%0b cls=%0d ea=%h phys=%h",
                    exp_tag, out_valid, bad_ptr, seg_stack, addr_class, ea, phys,
                    e_valid, e_bad, e_stack, e_cls, e_ea, e_phys);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic req(input logic [1:0] m, input logic [2:0] s, input logic [15:0] d,
                       input logic sh, input string t);
        @(negedge clk);
        in_valid = 1; mode = m; ptr_sel = s; disp = d; disp_short = sh; cur_tag = t;
    endtask

    task automatic idle(input logic [15:0] d, input string t);
        @(negedge clk);
        in_valid = 0; mode = 2'd2; ptr_sel = 3'd5; disp = d; disp_short = 0; cur_tag = t;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        req(2'd0, 3'd1, 16'h0050, 0, "R1 05C0:0050");
        req(2'd3, 3'd0, 16'h1234, 0, "R2 reserved as direct");
        req(2'd0, 3'd5, 16'hFFFE, 0, "R2 direct selector ignored");
        req(2'd1, 3'd6, 16'h7777, 0, "R3 indirect SI");
        req(2'd1, 3'd3, 16'h0002, 0, "R3 indirect BX");
        req(2'd2, 3'd3, 16'h0002, 0, "R4 based BX+2 R7");
        req(2'd2, 3'd5, 16'h0020, 0, "R4 R1 double wrap BP R6");
        req(2'd2, 3'd6, 16'hFFFE, 0, "R4 negative disp SI");
        req(2'd2, 3'd7, 16'h12FE, 1, "R5 short negative DI");
        req(2'd2, 3'd3, 16'hAB7F, 1, "R5 short positive upper ignored");
        req(2'd0, 3'd0, 16'h0080, 1, "R5 direct short");
        req(2'd1, 3'd5, 16'h0000, 0, "R6 BP stack segment");
        req(2'd1, 3'd7, 16'h0000, 0, "R7 DI indexed");
        req(2'd2, 3'd0, 16'h0010, 0, "R8 AX illegal");
        req(2'd1, 3'd1, 16'h0010, 0, "R8 CX illegal");
        req(2'd2, 3'd2, 16'h0010, 0, "R8 DX illegal");
        req(2'd1, 3'd4, 16'h0010, 0, "R8 SP illegal");
        req(2'd2, 3'd6, 16'h0003, 0, "R9 load");
        idle(16'h5555, "R9 hold");
        idle(16'hAAAA, "R9 hold");
        @(negedge clk); ss_val = 16'h1000; ds_val = 16'h2000;
        req(2'd2, 3'd5, 16'h8000, 0, "R1 R4 new segments");
        req(2'd0, 3'd0, 16'hFFFF, 0, "R1 direct top");
        @(negedge clk); rst = 1; in_valid = 1; cur_tag = "R10 reset";
        @(negedge clk); rst = 0; in_valid = 0; cur_tag = "R10 after reset";
        idle(16'h0000, "R9 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule